// File: doc/BRIEF.md
# Multi-Queue Instruction Dispatch Stage

This block sits between instruction decode and the issue stage of an out-of-order core. Decoded instructions arrive in program order, up to four per cycle, and wait in a twelve-entry in-order buffer. Each instruction carries a two-bit class tag. The tag selects the general-purpose issue queue, the floating-point issue queue, the vector issue queue, or none. Class none is for an instruction that needs only a completion slot.

Each cycle the stage looks at the three oldest buffered instructions. It sends as many of them as it can, strictly in order. It stops at the first one that cannot go. An instruction can go when its target issue queue still has room and is under that queue's per-cycle acceptance limit, and a completion-queue credit remains. Every dispatched instruction leaves with a completion tag. Tags are handed out consecutively, modulo the completion-queue depth.

The issue queues and the completion queue lie outside the block. They are seen only as free-space counts on the inputs. A flush input empties the buffer.

Top module: `dispatch_stage`

## Requirements
- R1: After reset the buffer is empty, no lane dispatches, and `in_ready` is 1. `in_ready` is 1 exactly when at least four of the twelve buffer entries are free. An offer made while `in_ready` is 0 is discarded.
- R2: At most three instructions dispatch per cycle, and only from the three oldest buffer entries. Lane 0 carries the oldest entry.
- R3: Dispatch is in order. If the instruction in lane k cannot dispatch, no younger lane dispatches in that cycle, and `disp_valid` is always a contiguous run starting at bit 0.
- R4: Per cycle, the floating-point queue accepts at most one instruction, the vector queue at most two and the general-purpose queue at most three.
- R5: The number of instructions of one class dispatched in a cycle never exceeds that class's free-space input. The free-space inputs are `gp_free` (0..6), `fp_free` (0..2) and `vec_free` (0..4).
- R6: The total dispatched in a cycle never exceeds `cq_free`. This includes class-none instructions, which need only completion credit.
- R7: The completion tag is 4 bits wide. It is 0 for the first instruction dispatched after reset, and each further dispatched instruction receives the previous tag plus one, modulo 16, in lane order. A flush does not reset the tag.
- R8: While `flush` is 1, nothing dispatches and offers are discarded. The buffer is empty after that clock edge, so in the next cycle nothing dispatches and `in_ready` is 1.
- R9: The class encoding is 0 = none, 1 = general-purpose, 2 = floating-point, 3 = vector. In `in_cls` and `disp_cls`, lane k occupies bits [2k+1:2k].
- R10: Accepted instructions dispatch in arrival order, with payload and class unchanged. Within one offer, lane 0 of `in_cls`/`in_payload` is the oldest. `in_count` gives the number of valid offer lanes, starting at lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flush | input | 1 | Discard all buffered instructions at the next edge |
| in_count | input | 3 | Number of valid offered instructions (0..4) |
| in_cls | input | 8 | Class tag of each offered instruction, 2 bits per lane |
| in_payload | input | 64 | Payload of each offered instruction, 16 bits per lane |
| in_ready | output | 1 | Buffer has room for four instructions |
| gp_free | input | 3 | Free entries in the general-purpose issue queue |
| fp_free | input | 2 | Free entries in the floating-point issue queue |
| vec_free | input | 3 | Free entries in the vector issue queue |
| cq_free | input | 5 | Free completion-queue slots |
| disp_valid | output | 3 | Dispatch lane valid, one bit per lane |
| disp_cls | output | 6 | Class of each dispatched instruction |
| disp_payload | output | 48 | Payload of each dispatched instruction |
| disp_tag | output | 12 | Completion tag of each dispatched instruction, 4 bits per lane |

## Verification
The dispatch lanes and `in_ready` are combinational from the registered buffer state and the present credit inputs, so they are due in the same cycle as the credits they depend on. An instruction accepted at a rising edge becomes eligible in the cycle that follows. A flush takes effect at the next edge. The bench drives inputs one nanosecond after the rising edge and samples on the falling edge. A scoreboard model updated at that falling edge predicts the lane count, classes, payloads and tags for exactly that cycle, and takes offers into its own buffer only when the predicted `in_ready` was 1.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_NONE = 2'd0,
    CLS_GP   = 2'd1,
    CLS_FP   = 2'd2,
    CLS_VEC  = 2'd3
  } instr_cls_e;
endpackage

// File: rtl/dispatch_iq.sv
module dispatch_iq #(
  parameter int DEPTH  = 12,
  parameter int EW     = 18,
  parameter int PUSH_W = 4,
  parameter int POP_W  = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic [$clog2(PUSH_W+1)-1:0]      push_n,
  input  logic [PUSH_W*EW-1:0]             push_data,
  input  logic [$clog2(POP_W+1)-1:0]       pop_n,
  output logic [POP_W*EW-1:0]              head_data,
  output logic [POP_W-1:0]                 head_valid,
  output logic                             room_ok
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PN_W  = $clog2(PUSH_W + 1);

  logic [EW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic [PN_W-1:0]  push_eff;

  function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] ptr, input int k);
    int s;
    s = int'(ptr) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  assign room_ok = (int'(count_q) + PUSH_W) <= DEPTH;

  always_comb begin
    push_eff = (flush || !room_ok) ? '0 : push_n;
    if (flush) begin
      head_d  = '0;
      tail_d  = '0;
      count_d = '0;
    end else begin
      head_d  = wrap_add(head_q, int'(pop_n));
      tail_d  = wrap_add(tail_q, int'(push_eff));
      count_d = CNT_W'(int'(count_q) + int'(push_eff) - int'(pop_n));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < PUSH_W; k++) begin
      if (k < int'(push_eff)) mem[wrap_add(tail_q, k)] <= push_data[k*EW +: EW];
    end
  end

  always_comb begin
    for (int j = 0; j < POP_W; j++) begin
      head_data[j*EW +: EW] = mem[wrap_add(head_q, j)];
      head_valid[j]         = j < int'(count_q);
    end
  end
endmodule

// File: rtl/dispatch_select.sv
module dispatch_select
  import dispatch_pkg::*;
#(
  parameter int DISP_W  = 3,
  parameter int GP_LIM  = 3,
  parameter int FP_LIM  = 1,
  parameter int VEC_LIM = 2,
  parameter int GPF_W   = 3,
  parameter int FPF_W   = 2,
  parameter int VECF_W  = 3,
  parameter int CQF_W   = 5
) (
  input  logic                           block,
  input  logic [DISP_W-1:0]              head_valid,
  input  logic [DISP_W*CLS_W-1:0]        head_cls,
  input  logic [GPF_W-1:0]               gp_free,
  input  logic [FPF_W-1:0]               fp_free,
  input  logic [VECF_W-1:0]              vec_free,
  input  logic [CQF_W-1:0]               cq_free,
  output logic [DISP_W-1:0]              take,
  output logic [$clog2(DISP_W+1)-1:0]    n_take
);
  localparam int TAKE_W = $clog2(DISP_W + 1);

  int unsigned gp_u, fp_u, vec_u, all_u;
  logic        go, fits;
  instr_cls_e  cls;

  always_comb begin
    gp_u  = 0;
    fp_u  = 0;
    vec_u = 0;
    all_u = 0;
    go    = !block;
    take  = '0;
    for (int i = 0; i < DISP_W; i++) begin
      cls = instr_cls_e'(head_cls[i*CLS_W +: CLS_W]);
      unique case (cls)
        CLS_GP:  fits = (gp_u < GP_LIM) && (gp_u < 32'(gp_free));
        CLS_FP:  fits = (fp_u < FP_LIM) && (fp_u < 32'(fp_free));
        CLS_VEC: fits = (vec_u < VEC_LIM) && (vec_u < 32'(vec_free));
        default: fits = 1'b1;
      endcase
      take[i] = go && head_valid[i] && fits && (all_u < 32'(cq_free));
      if (take[i]) begin
        all_u = all_u + 1;
        if (cls == CLS_GP)  gp_u  = gp_u + 1;
        if (cls == CLS_FP)  fp_u  = fp_u + 1;
        if (cls == CLS_VEC) vec_u = vec_u + 1;
      end else begin
        go = 1'b0;
      end
    end
    n_take = TAKE_W'(all_u);
  end
endmodule

// File: rtl/dispatch_tags.sv
module dispatch_tags #(
  parameter int DISP_W = 3,
  parameter int TAG_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(DISP_W+1)-1:0]   n_take,
  output logic [DISP_W*TAG_W-1:0]       tags
);
  logic [TAG_W-1:0] base_q, base_d;

  always_comb begin
    base_d = base_q + TAG_W'(n_take);
    for (int d = 0; d < DISP_W; d++) tags[d*TAG_W +: TAG_W] = base_q + TAG_W'(d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end
endmodule

// File: rtl/dispatch_stage.sv
module dispatch_stage
  import dispatch_pkg::*;
#(
  parameter int IQ_DEPTH = 12,
  parameter int FETCH_W  = 4,
  parameter int DISP_W   = 3,
  parameter int PW       = 16,
  parameter int GP_LIM   = 3,
  parameter int FP_LIM   = 1,
  parameter int VEC_LIM  = 2,
  parameter int GP_CAP   = 6,
  parameter int FP_CAP   = 2,
  parameter int VEC_CAP  = 4,
  parameter int CQ_DEPTH = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 flush,
  input  logic [$clog2(FETCH_W+1)-1:0]         in_count,
  input  logic [FETCH_W*2-1:0]                 in_cls,
  input  logic [FETCH_W*PW-1:0]                in_payload,
  output logic                                 in_ready,
  input  logic [$clog2(GP_CAP+1)-1:0]          gp_free,
  input  logic [$clog2(FP_CAP+1)-1:0]          fp_free,
  input  logic [$clog2(VEC_CAP+1)-1:0]         vec_free,
  input  logic [$clog2(CQ_DEPTH+1)-1:0]        cq_free,
  output logic [DISP_W-1:0]                    disp_valid,
  output logic [DISP_W*2-1:0]                  disp_cls,
  output logic [DISP_W*PW-1:0]                 disp_payload,
  output logic [DISP_W*$clog2(CQ_DEPTH)-1:0]   disp_tag
);
  localparam int EW     = PW + CLS_W;
  localparam int PN_W   = $clog2(FETCH_W + 1);
  localparam int TAKE_W = $clog2(DISP_W + 1);
  localparam int TAG_W  = $clog2(CQ_DEPTH);

  logic [FETCH_W*EW-1:0] push_data;
  logic [PN_W-1:0]       push_n;
  logic [DISP_W*EW-1:0]  head_data;
  logic [DISP_W-1:0]     head_valid;
  logic [DISP_W*CLS_W-1:0] head_cls;
  logic [TAKE_W-1:0]     n_take;

  always_comb begin
    if (flush)                          push_n = '0;
    else if (int'(in_count) > FETCH_W)  push_n = PN_W'(FETCH_W);
    else                                push_n = in_count;
  end

  for (genvar k = 0; k < FETCH_W; k++) begin : g_pack
    assign push_data[k*EW +: EW] = {in_cls[k*CLS_W +: CLS_W], in_payload[k*PW +: PW]};
  end

  for (genvar j = 0; j < DISP_W; j++) begin : g_lane
    assign head_cls[j*CLS_W +: CLS_W] = head_data[j*EW + PW +: CLS_W];
    assign disp_cls[j*CLS_W +: CLS_W] = head_cls[j*CLS_W +: CLS_W];
    assign disp_payload[j*PW +: PW]   = head_data[j*EW +: PW];
  end

  dispatch_iq #(
    .DEPTH (IQ_DEPTH), .EW(EW), .PUSH_W(FETCH_W), .POP_W(DISP_W)
  ) u_iq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_n(push_n), .push_data(push_data), .pop_n(n_take),
    .head_data(head_data), .head_valid(head_valid), .room_ok(in_ready)
  );

  dispatch_select #(
    .DISP_W(DISP_W), .GP_LIM(GP_LIM), .FP_LIM(FP_LIM), .VEC_LIM(VEC_LIM),
    .GPF_W($clog2(GP_CAP+1)), .FPF_W($clog2(FP_CAP+1)),
    .VECF_W($clog2(VEC_CAP+1)), .CQF_W($clog2(CQ_DEPTH+1))
  ) u_sel (
    .block(flush), .head_valid(head_valid), .head_cls(head_cls),
    .gp_free(gp_free), .fp_free(fp_free), .vec_free(vec_free), .cq_free(cq_free),
    .take(disp_valid), .n_take(n_take)
  );

  dispatch_tags #(.DISP_W(DISP_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .n_take(n_take), .tags(disp_tag)
  );
endmodule

// File: rtl/dispatch_stage_chk.sv
module dispatch_stage_chk
  import dispatch_pkg::*;
#(
  parameter int DISP_W  = 3,
  parameter int FP_LIM  = 1,
  parameter int VEC_LIM = 2,
  parameter int GP_LIM  = 3,
  parameter int GPF_W   = 3,
  parameter int FPF_W   = 2,
  parameter int VECF_W  = 3,
  parameter int CQF_W   = 5,
  parameter int TAG_W   = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      flush,
  input logic                      in_ready,
  input logic [GPF_W-1:0]          gp_free,
  input logic [FPF_W-1:0]          fp_free,
  input logic [VECF_W-1:0]         vec_free,
  input logic [CQF_W-1:0]          cq_free,
  input logic [DISP_W-1:0]         disp_valid,
  input logic [DISP_W*2-1:0]       disp_cls,
  input logic [DISP_W*TAG_W-1:0]   disp_tag
);
  logic [DISP_W-1:0] gp_hits, fp_hits, vec_hits;
  int                n_disp;

  for (genvar i = 0; i < DISP_W; i++) begin : g_hit
    assign gp_hits[i]  = disp_valid[i] && (disp_cls[i*2 +: 2] == CLS_GP);
    assign fp_hits[i]  = disp_valid[i] && (disp_cls[i*2 +: 2] == CLS_FP);
    assign vec_hits[i] = disp_valid[i] && (disp_cls[i*2 +: 2] == CLS_VEC);
  end
  assign n_disp = $countones(disp_valid);

  for (genvar i = 1; i < DISP_W; i++) begin : g_order
    // R3
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid[i] |-> disp_valid[i-1]);
  end

  // R4
  fp_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fp_hits) <= FP_LIM);

  // R4
  vec_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vec_hits) <= VEC_LIM);

  // R5
  gp_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(gp_hits) <= int'(gp_free)) && ($countones(gp_hits) <= GP_LIM));

  // R5
  fp_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(fp_hits) <= int'(fp_free)) && ($countones(vec_hits) <= int'(vec_free)));

  // R6
  cq_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_disp <= int'(cq_free));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (disp_valid == '0));

  // R8
  flush_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> in_ready);

  // R7
  tag_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> disp_tag[TAG_W-1:0] == TAG_W'(int'($past(disp_tag[TAG_W-1:0])) + $past(n_disp)));
endmodule

bind dispatch_stage dispatch_stage_chk #(
  .DISP_W(DISP_W), .FP_LIM(FP_LIM), .VEC_LIM(VEC_LIM), .GP_LIM(GP_LIM),
  .GPF_W($clog2(GP_CAP+1)), .FPF_W($clog2(FP_CAP+1)), .VECF_W($clog2(VEC_CAP+1)),
  .CQF_W($clog2(CQ_DEPTH+1)), .TAG_W($clog2(CQ_DEPTH))
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_ready(in_ready),
  .gp_free(gp_free), .fp_free(fp_free), .vec_free(vec_free), .cq_free(cq_free),
  .disp_valid(disp_valid), .disp_cls(disp_cls), .disp_tag(disp_tag)
);

// File: tb/sim_dispatch_stage.sv
module sim_dispatch_stage;
  localparam int DEPTH = 12, FW = 4, DW = 3, PW = 16, EW = PW + 2, TW = 4;

  logic          clk, rst_n, flush, in_ready;
  logic [2:0]    in_count;
  logic [FW*2-1:0]  in_cls;
  logic [FW*PW-1:0] in_payload;
  logic [2:0]    gp_free, vec_free;
  logic [1:0]    fp_free;
  logic [4:0]    cq_free;
  logic [DW-1:0] disp_valid;
  logic [DW*2-1:0]  disp_cls;
  logic [DW*PW-1:0] disp_payload;
  logic [DW*TW-1:0] disp_tag;

  dispatch_stage u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_count(in_count), .in_cls(in_cls),
    .in_payload(in_payload), .in_ready(in_ready), .gp_free(gp_free), .fp_free(fp_free),
    .vec_free(vec_free), .cq_free(cq_free), .disp_valid(disp_valid), .disp_cls(disp_cls),
    .disp_payload(disp_payload), .disp_tag(disp_tag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, fails = 0, exp_tag = 0, seq = 1;
  bit running = 0, done = 0;
  logic [EW-1:0] model_q[$];
  logic [EW-1:0] offer_q[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // driver: offers n instructions (lane 0 oldest) and records them as candidates
  task automatic offer(input int n, input logic [1:0] c0, c1, c2, c3);
    logic [1:0] cs[4];
    cs = '{c0, c1, c2, c3};
    in_count = 3'(n);
    for (int k = 0; k < FW; k++) begin
      in_cls[k*2 +: 2]      = cs[k];
      in_payload[k*PW +: PW] = PW'(seq);
      if (k < n) offer_q.push_back({cs[k], PW'(seq)});
      seq++;
    end
  endtask

  task automatic credits(input int g, input int f, input int v, input int c);
    gp_free = 3'(g); fp_free = 2'(f); vec_free = 3'(v); cq_free = 5'(c);
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_count = '0;
      flush = 1'b0;
    end
  endtask

  // monitor / scoreboard
  int gp_u, fp_u, vec_u, n_exp, got;
  bit exp_rdy, fit;
  logic [1:0] c;
  always @(negedge clk) begin
    if (running) begin
      exp_rdy = model_q.size() <= DEPTH - FW;
      chk(in_ready == exp_rdy, "R1", "in_ready", int'(in_ready), int'(exp_rdy));
      n_exp = 0; gp_u = 0; fp_u = 0; vec_u = 0;
      if (!flush) begin
        for (int i = 0; i < DW && i < model_q.size(); i++) begin
          c = model_q[i][EW-1 -: 2];
          case (c)
            2'd1: fit = gp_u < 3 && gp_u < int'(gp_free);
            2'd2: fit = fp_u < 1 && fp_u < int'(fp_free);
            2'd3: fit = vec_u < 2 && vec_u < int'(vec_free);
            default: fit = 1;
          endcase
          if (!fit || n_exp >= int'(cq_free)) break;
          n_exp++;
          if (c == 2'd1) gp_u++;
          if (c == 2'd2) fp_u++;
          if (c == 2'd3) vec_u++;
        end
      end
      got = $countones(disp_valid);
      chk(got == n_exp, "R2 R3 R4 R5 R6 R9", "dispatch count", got, n_exp);
      for (int i = 0; i < n_exp && i < got; i++) begin
        chk({disp_cls[i*2 +: 2], disp_payload[i*PW +: PW]} == model_q[i], "R10", "lane item",
            int'({disp_cls[i*2 +: 2], disp_payload[i*PW +: PW]}), int'(model_q[i]));
        chk(int'(disp_tag[i*TW +: TW]) == (exp_tag + i) % 16, "R7", "lane tag",
            int'(disp_tag[i*TW +: TW]), (exp_tag + i) % 16);
      end
      for (int i = 0; i < n_exp; i++) void'(model_q.pop_front());
      exp_tag = (exp_tag + n_exp) % 16;
      if (flush) model_q.delete();
      if (exp_rdy && !flush) foreach (offer_q[k]) model_q.push_back(offer_q[k]);
      offer_q.delete();
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", "cycles", 100000, 0);
    finish_run();
  end

  initial begin
    rst_n = 0; flush = 0; in_count = 0; in_cls = '0; in_payload = '0;
    credits(6, 2, 4, 16);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(disp_valid == '0, "R1", "reset disp_valid", int'(disp_valid), 0);
    chk(in_ready == 1'b1, "R1", "reset in_ready", int'(in_ready), 1);
    @(posedge clk); #1;
    running = 1;

    // R2: four general-purpose, three then one
    offer(4, 1, 1, 1, 1); tick(4);
    // R4: floating-point one per cycle, general held behind (R3)
    offer(4, 2, 2, 2, 1); tick(5);
    // R4: vector two per cycle
    offer(4, 3, 3, 3, 1); tick(4);
    // R9: every class in one offer
    offer(4, 0, 1, 2, 3); tick(4);
    // R5: general-purpose room of one
    credits(1, 2, 4, 16);
    offer(4, 1, 1, 1, 1); tick(6);
    credits(6, 0, 4, 16);
    offer(2, 2, 1, 0, 0); tick(3);
    credits(6, 2, 4, 16); tick(2);
    // R6 and R1: no completion credit, fill to 12, then a refused offer
    credits(6, 2, 4, 0);
    offer(4, 0, 1, 3, 2); tick();
    offer(4, 1, 0, 1, 3); tick();
    offer(4, 3, 1, 0, 0); tick();
    offer(4, 1, 1, 1, 1); tick(2);
    credits(6, 2, 4, 1); tick(3);
    credits(6, 2, 4, 2); tick(3);
    credits(6, 2, 4, 16); tick(6);
    // R8: flush with a full-ish queue and a simultaneous offer
    credits(6, 2, 4, 0);
    offer(4, 1, 2, 3, 0); tick();
    offer(4, 1, 1, 1, 1); tick();
    flush = 1; credits(6, 2, 4, 16); offer(4, 1, 1, 1, 1); tick();
    @(negedge clk);
    chk(disp_valid == '0, "R8", "after flush disp_valid", int'(disp_valid), 0);
    chk(in_ready == 1'b1, "R8", "after flush in_ready", int'(in_ready), 1);
    @(posedge clk); #1;
    offer(3, 3, 0, 2, 0); tick(4);
    // mixed traffic with random credits and occasional flushes
    for (int t = 0; t < 600; t++) begin
      credits($urandom_range(0, 6), $urandom_range(0, 2), $urandom_range(0, 4), $urandom_range(0, 16));
      offer($urandom_range(0, 4), 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom));
      if ($urandom_range(0, 39) == 0) flush = 1;
      tick();
    end
    credits(6, 2, 4, 16); tick(12);
    @(negedge clk);
    chk(model_q.size() == 0, "R10", "drained model", model_q.size(), 0);
    chk(disp_valid == '0, "R10", "drained disp_valid", int'(disp_valid), 0);
    finish_run();
  end
endmodule